// File: doc/BRIEF.md
# Power-of-Two Threshold Data Queue

A synchronous first-in first-out buffer for 32-bit data words, meant to sit between a bus-side agent and a serial-transfer engine as either the outbound (transmit) or the inbound (receive) data buffer. Words enter through a valid/ready push handshake and leave through a valid/ready pop handshake. The head word is always visible on the pop data output while the queue holds anything.

Beside the usual empty and full flags, the block raises a level flag meant for an interrupt source. Software picks the level as a 3-bit exponent code N, and the level in words is two to the power N+1. A build-time mode parameter decides what is measured. In transmit mode the flag means "at least that many free slots", so the producer can refill. In receive mode it means "at least that many words stored", so the consumer can drain. A code that asks for more than the queue can express is replaced by a fixed, depth-dependent code, and the replacement differs between the two modes.

Top module: `pow2_thld_queue`

## Requirements
- R1: After synchronous reset the queue is empty: `empty`=1, `full`=0, `pop_valid`=0 and `push_ready`=1. In transmit mode `thld_hit`=1 for every code and in receive mode `thld_hit`=0.
- R2: Words leave on `pop_data` in the order they were accepted, and `pop_data` shows the head word whenever `pop_valid`=1.
- R3: While `full`=1, `push_ready`=0 and a push attempt leaves the stored contents unchanged.
- R4: While `empty`=1, `pop_valid`=0 and a pop attempt leaves the occupancy unchanged.
- R5: A push and a pop accepted in the same cycle leave the occupancy, and so `empty` and `full`, unchanged.
- R6: `empty`=1 exactly when zero words are stored and `full`=1 exactly when DEPTH words are stored.
- R7: The effective level for an in-range code N (3 bits, 0 to 7) is 2^(N+1) words.
- R8: With MODE=transmit, `thld_hit`=1 exactly when DEPTH minus the stored count is at least the effective level.
- R9: With MODE=receive, `thld_hit`=1 exactly when the stored count is at least the effective level.
- R10: With MODE=transmit, a code whose level 2^(N+1) exceeds DEPTH is replaced by log2(DEPTH)-1, giving a level of DEPTH.
- R11: With MODE=receive, a code whose level 2^(N+1) is DEPTH or more is replaced by log2(DEPTH)-2, giving a level of DEPTH/2.
- R12: The code is applied combinationally: a change on `thld_code` is reflected on `thld_hit` in the same cycle, with no push or pop.
- R13: DEPTH is a power of two of at least 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | 1 | Producer offers a word |
| push_data | input | 32 | Word offered by the producer |
| push_ready | output | 1 | Queue can accept a word |
| pop_valid | output | 1 | Head word is available |
| pop_data | output | 32 | Head word |
| pop_ready | input | 1 | Consumer takes the head word |
| thld_code | input | 3 | Exponent code N of the level |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| thld_hit | output | 1 | Level condition met |

## Verification
The level flag is swept over all eight codes at every occupancy from empty to full, in both modes. This separates the free-slot and stored-word measures, exposes off-by-one errors at each power-of-two boundary, and shows the two clamp rules apart. In the receive build, code 2 already clamps while code 1 does not. The data path is tried with a short burst, a fill past capacity, a pop on an empty queue and back-to-back combined push and pop. Together these show order, dropped overflow words, and that no phantom entry or count change appears.

// File: rtl/pow2q_pkg.sv
`timescale 1ns/1ps
package pow2q_pkg;

    localparam int CODE_W = 3;

    typedef enum logic {
        Q_TX = 1'b0,
        Q_RX = 1'b1
    } qmode_e;

    typedef struct packed {
        logic push;
        logic pop;
    } q_xfer_t;

    // Replace a code whose level the queue cannot express.
    function automatic logic [CODE_W-1:0] clamp_code(
        input logic [CODE_W-1:0] code,
        input qmode_e            mode,
        input int                lg
    );
        int lvl;
        int cap;
        lvl = 1 << (int'(code) + 1);
        cap = 1 << lg;
        if (mode == Q_TX) begin
            if (lvl > cap) return CODE_W'(lg - 1);
        end else begin
            if (lvl >= cap) return CODE_W'(lg - 2);
        end
        return code;
    endfunction

endpackage

// File: rtl/pow2q_store.sv
`timescale 1ns/1ps
module pow2q_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  pow2q_pkg::q_xfer_t xfer,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (xfer.push) wr_ptr <= wr_ptr + AW'(1);
            if (xfer.pop)  rd_ptr <= rd_ptr + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (xfer.push) mem[wr_ptr] <= wr_data;
    end

    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/pow2q_level.sv
`timescale 1ns/1ps
module pow2q_level #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  pow2q_pkg::q_xfer_t xfer,
    output logic [CW-1:0]      level,
    output logic               empty,
    output logic               full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else begin
            unique case ({xfer.push, xfer.pop})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end

    assign empty = (level == '0);
    assign full  = (level == CW'(DEPTH));

endmodule

// File: rtl/pow2q_thld.sv
`timescale 1ns/1ps
module pow2q_thld
    import pow2q_pkg::*;
#(
    parameter int     DEPTH = 16,
    parameter qmode_e MODE  = Q_TX,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CW-1:0]     level,
    output logic              hit
);
    localparam int LG = $clog2(DEPTH);

    logic [CODE_W-1:0] eff_code;
    logic [CODE_W:0]   shamt;
    logic [CW-1:0]     lvl_words;

    assign eff_code  = clamp_code(code, MODE, LG);
    assign shamt     = {1'b0, eff_code} + (CODE_W+1)'(1);
    assign lvl_words = CW'(1) << shamt;

    generate
        if (MODE == Q_TX) begin : g_tx
            logic [CW-1:0] free_slots;
            assign free_slots = CW'(DEPTH) - level;
            assign hit = (free_slots >= lvl_words);
        end else begin : g_rx
            assign hit = (level >= lvl_words);
        end
    endgenerate

endmodule

// File: rtl/pow2_thld_queue.sv
`timescale 1ns/1ps
module pow2_thld_queue
    import pow2q_pkg::*;
#(
    parameter int     DEPTH = 16,
    parameter qmode_e MODE  = Q_TX
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push_valid,
    input  logic [31:0] push_data,
    output logic        push_ready,
    output logic        pop_valid,
    output logic [31:0] pop_data,
    input  logic        pop_ready,
    input  logic [2:0]  thld_code,
    output logic        empty,
    output logic        full,
    output logic        thld_hit
);
    localparam int WIDTH = 32;
    localparam int CW    = $clog2(DEPTH) + 1;

    q_xfer_t       xfer;
    logic [CW-1:0] level;

    assign push_ready = !full;
    assign pop_valid  = !empty;
    assign xfer.push  = push_valid && push_ready;
    assign xfer.pop   = pop_ready && pop_valid;

    pow2q_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .xfer    (xfer),
        .wr_data (push_data),
        .rd_data (pop_data)
    );

    pow2q_level #(.DEPTH(DEPTH)) u_level (
        .clk   (clk),
        .rst   (rst),
        .xfer  (xfer),
        .level (level),
        .empty (empty),
        .full  (full)
    );

    pow2q_thld #(.DEPTH(DEPTH), .MODE(MODE)) u_thld (
        .code  (thld_code),
        .level (level),
        .hit   (thld_hit)
    );

endmodule

// File: rtl/pow2_thld_queue_chk.sv
`timescale 1ns/1ps
module pow2_thld_queue_chk
    import pow2q_pkg::*;
#(
    parameter int     DEPTH = 16,
    parameter qmode_e MODE  = Q_TX
) (
    input logic        clk,
    input logic        rst,
    input logic        push_valid,
    input logic        push_ready,
    input logic        pop_valid,
    input logic [31:0] pop_data,
    input logic        pop_ready,
    input logic [2:0]  thld_code,
    input logic        empty,
    input logic        full,
    input logic        thld_hit
);
    int  cnt;
    int  lvl;
    logic exp_hit;
    logic acc_push;
    logic acc_pop;

    assign acc_push = push_valid && push_ready;
    assign acc_pop  = pop_valid && pop_ready;

    always_ff @(posedge clk) begin
        if (rst) cnt <= 0;
        else     cnt <= cnt + (acc_push ? 1 : 0) - (acc_pop ? 1 : 0);
    end

    always_comb begin
        lvl = 1 << (int'(thld_code) + 1);
        if (MODE == Q_TX) begin
            if (lvl > DEPTH) lvl = DEPTH;
            exp_hit = (DEPTH - cnt) >= lvl;
        end else begin
            if (lvl >= DEPTH) lvl = DEPTH / 2;
            exp_hit = cnt >= lvl;
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        full |-> !push_ready);
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        empty |-> !pop_valid);
    p_hold_level_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_push && acc_pop) |=> ($stable(empty) && $stable(full)));
    p_empty_count_r6: assert property (@(posedge clk) disable iff (rst)
        empty == (cnt == 0));
    p_full_count_r6: assert property (@(posedge clk) disable iff (rst)
        full == (cnt == DEPTH));
    p_head_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (pop_valid && !pop_ready) |=> $stable(pop_data));
    generate
        if (MODE == Q_TX) begin : g_tx
            p_tx_level_r8: assert property (@(posedge clk) disable iff (rst)
                thld_hit == exp_hit);
        end else begin : g_rx
            p_rx_level_r9: assert property (@(posedge clk) disable iff (rst)
                thld_hit == exp_hit);
        end
    endgenerate

endmodule

bind pow2_thld_queue pow2_thld_queue_chk #(.DEPTH(DEPTH), .MODE(MODE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .pop_valid  (pop_valid),
    .pop_data   (pop_data),
    .pop_ready  (pop_ready),
    .thld_code  (thld_code),
    .empty      (empty),
    .full       (full),
    .thld_hit   (thld_hit)
);

// File: tb/pow2_thld_queue_test.sv
`timescale 1ns/1ps
module pow2_thld_queue_test;
    import pow2q_pkg::*;

    localparam int TX_DEPTH = 16;
    localparam int RX_DEPTH = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        tx_pv = 0, tx_pr = 0, tx_prdy, tx_pvld, tx_emp, tx_ful, tx_hit;
    logic [31:0] tx_pd = 0, tx_qd;
    logic [2:0]  tx_code = 0;
    logic        rx_pv = 0, rx_pr = 0, rx_prdy, rx_pvld, rx_emp, rx_ful, rx_hit;
    logic [31:0] rx_pd = 0, rx_qd;
    logic [2:0]  rx_code = 0;

    pow2_thld_queue #(.DEPTH(TX_DEPTH), .MODE(Q_TX)) uut (
        .clk(clk), .rst(rst), .push_valid(tx_pv), .push_data(tx_pd),
        .push_ready(tx_prdy), .pop_valid(tx_pvld), .pop_data(tx_qd),
        .pop_ready(tx_pr), .thld_code(tx_code), .empty(tx_emp),
        .full(tx_ful), .thld_hit(tx_hit));

    pow2_thld_queue #(.DEPTH(RX_DEPTH), .MODE(Q_RX)) uut_rx (
        .clk(clk), .rst(rst), .push_valid(rx_pv), .push_data(rx_pd),
        .push_ready(rx_prdy), .pop_valid(rx_pvld), .pop_data(rx_qd),
        .pop_ready(rx_pr), .thld_code(rx_code), .empty(rx_emp),
        .full(rx_ful), .thld_hit(rx_hit));

    int checks = 0;
    int failures = 0;
    int occ [2] = '{0, 0};
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle starting at a falling edge; returns at the next falling edge.
    task automatic cyc(input int m, input bit pu, input bit po, input logic [31:0] d);
        bit ap, ao;
        if (m == 0) begin
            tx_pv = pu; tx_pr = po; tx_pd = d;
            ap = pu && tx_prdy; ao = po && tx_pvld;
        end else begin
            rx_pv = pu; rx_pr = po; rx_pd = d;
            ap = pu && rx_prdy; ao = po && rx_pvld;
        end
        @(negedge clk);
        tx_pv = 0; tx_pr = 0; rx_pv = 0; rx_pr = 0;
        occ[m] = occ[m] + int'(ap) - int'(ao);
    endtask

    function automatic logic exp_hit(input int m, input int code, input int n);
        int depth, lvl;
        depth = (m == 0) ? TX_DEPTH : RX_DEPTH;
        lvl = 1 << (code + 1);
        if (m == 0) begin
            if (lvl > depth) lvl = depth;
            return (depth - n) >= lvl;
        end
        if (lvl >= depth) lvl = depth / 2;
        return n >= lvl;
    endfunction

    task automatic t_reset();
        chk(tx_emp == 1 && tx_ful == 0, "R1", "tx empty/full", {tx_emp, tx_ful}, 2'b10);
        chk(tx_prdy == 1 && tx_pvld == 0, "R1", "tx ready/valid", {tx_prdy, tx_pvld}, 2'b10);
        chk(rx_emp == 1 && rx_ful == 0, "R1", "rx empty/full", {rx_emp, rx_ful}, 2'b10);
        for (int c = 0; c < 8; c++) begin
            tx_code = 3'(c); rx_code = 3'(c); #1;
            chk(tx_hit == 1, "R1", "tx hit at reset", tx_hit, 1);
            chk(rx_hit == 0, "R1", "rx hit at reset", rx_hit, 0);
        end
    endtask

    task automatic t_order();
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, 32'hA000 + i);
        for (int i = 0; i < 5; i++) begin
            chk(tx_pvld && tx_qd == 32'hA000 + i, "R2", "order", tx_qd, 32'hA000 + i);
            cyc(0, 0, 1, 0);
        end
        chk(tx_emp == 1, "R6", "empty after drain", tx_emp, 1);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < TX_DEPTH; i++) begin
            chk(tx_ful == 0, "R6", "not full yet", tx_ful, 0);
            cyc(0, 1, 0, 32'h100 + i);
        end
        chk(tx_ful == 1 && tx_prdy == 0, "R3", "full blocks push", {tx_ful, tx_prdy}, 2'b10);
        cyc(0, 1, 0, 32'hDEAD);
        chk(tx_ful == 1, "R3", "still full", tx_ful, 1);
        for (int i = 0; i < TX_DEPTH; i++) begin
            chk(tx_qd == 32'h100 + i, "R3", "contents kept", tx_qd, 32'h100 + i);
            cyc(0, 0, 1, 0);
        end
        chk(tx_emp == 1 && tx_pvld == 0, "R3", "no extra word", tx_pvld, 0);
    endtask

    task automatic t_underflow();
        chk(rx_pvld == 0, "R4", "no valid when empty", rx_pvld, 0);
        cyc(1, 0, 1, 0);
        cyc(1, 1, 0, 32'h55);
        chk(rx_emp == 0 && rx_qd == 32'h55, "R4", "one word after empty pop", rx_qd, 32'h55);
        cyc(1, 0, 1, 0);
        chk(rx_emp == 1, "R4", "count back to zero", rx_emp, 1);
    endtask

    task automatic t_simul();
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, 32'hB0 + i);
        for (int i = 0; i < 4; i++) begin
            cyc(1, 1, 1, 32'hB3 + i);
            chk(rx_emp == 0 && rx_ful == 0, "R5", "flags kept", {rx_emp, rx_ful}, 0);
        end
        for (int i = 0; i < 3; i++) begin
            chk(rx_qd == 32'hB4 + i, "R5", "order after combined", rx_qd, 32'hB4 + i);
            cyc(1, 0, 1, 0);
        end
        chk(rx_emp == 1, "R5", "occupancy unchanged by combined", rx_emp, 1);
    endtask

    // Sweeps every code at every occupancy; code changes are checked with no clock edge (R12).
    task automatic t_sweep(input int m);
        int depth;
        depth = (m == 0) ? TX_DEPTH : RX_DEPTH;
        for (int n = 0; n <= depth; n++) begin
            for (int c = 0; c < 8; c++) begin
                logic h, e;
                if (m == 0) tx_code = 3'(c); else rx_code = 3'(c);
                #1;
                h = (m == 0) ? tx_hit : rx_hit;
                e = exp_hit(m, c, occ[m]);
                if (m == 0 && c >= 4)
                    chk(h == e, "R10", "tx clamped level", h, e);
                else if (m == 1 && c >= 2)
                    chk(h == e, "R11", "rx clamped level", h, e);
                else if (m == 0)
                    chk(h == e, "R8", "tx free-slot level R7 R12", h, e);
                else
                    chk(h == e, "R9", "rx stored level R7 R12", h, e);
            end
            @(negedge clk);
            if (n < depth) cyc(m, 1, 0, 32'(n));
        end
        chk(((m == 0) ? tx_ful : rx_ful) == 1, "R6", "full at depth", 0, 1);
        for (int n = 0; n < depth; n++) cyc(m, 0, 1, 0);
        chk(((m == 0) ? tx_emp : rx_emp) == 1, "R6", "empty after drain", 0, 1);
    endtask

    initial begin
        // R13: both builds use power-of-two depths of at least 4.
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        @(negedge clk);
        t_order();
        t_overflow();
        t_underflow();
        t_simul();
        t_sweep(0);
        t_sweep(1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule